// File: doc/BRIEF.md
# Write-Only Two-Wire Register Bank Target

This block is a target on a two-wire serial bus (SCL clock, SDA data, open-drain). It only accepts write transfers and uses them to load a bank of eight 8-bit control registers, which it presents as one flat parallel output. Its 7-bit device address has a fixed upper part and two bits taken from strap inputs, so up to four copies can share one bus. SCL and SDA are oversampled by the system clock through a synchroniser. START and STOP are found from SDA edges while SCL is high.

After an accepted address byte, the first byte is a subaddress. If its five low bits are all ones, the transfer becomes a burst: every following data byte goes to the next register, starting at register 0. Otherwise the transfer runs in pair mode, where subaddress and data bytes alternate until STOP. Each data byte goes to the register named by the subaddress just before it. Every register update lasts one system-clock cycle and is flagged on a write strobe together with the register index.

Top module: `wo_i2c_regbank`

## Requirements
- R1: The target acknowledges an address byte only when bits 7..3 are 1,0,0,1,1, bit 2 equals strap_i[1], bit 1 equals strap_i[0] and bit 0 is 0. Any other address byte is not acknowledged, and the rest of that transfer is ignored.
- R2: An address byte with bit 0 (read/write) at 1 is never acknowledged, and it causes no register write.
- R3: After an accepted address, every byte of the transfer (address, subaddress, data) is acknowledged by pulling SDA low for the ninth SCL clock. SDA is taken and released only while SCL is low.
- R4: In pair mode, a data byte is written to the register whose index equals the preceding subaddress (0 to 7). Several subaddress/data pairs can follow one address.
- R5: In pair mode, a subaddress of 8 or more whose five low bits are not all ones is acknowledged. Its data byte is also acknowledged, but it changes no register and produces no strobe.
- R6: A subaddress whose bits 4..0 are all 1 starts a burst, whatever its bits 7..5 are. The following data bytes are written to registers 0, 1, 2, ... in order until STOP.
- R7: In a burst, data bytes after register 7 has been written are acknowledged and discarded.
- R8: A repeated START aborts the current sequence, and the next byte is taken as an address byte.
- R9: Each register write changes exactly one register. wr_stb_o is high for exactly one clock in the cycle where the new value first appears on regs_o, with wr_idx_o giving its index. regs_o changes at no other time.
- R10: Reset (rst high, synchronous) clears all registers to zero and leaves sda_oe_o and wr_stb_o low.
- R11: A STOP ends the transfer. A byte cut short by a STOP writes nothing, and a later transfer works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| strap_i | input | 2 | Address straps: [1] is address bit 2, [0] is address bit 1 |
| regs_o | output | 64 | Register bank, register i at bits [8*i+7 : 8*i] |
| wr_stb_o | output | 1 | One-cycle pulse when a register has just been written |
| wr_idx_o | output | 3 | Index of the register written, valid with wr_stb_o |

## Verification
The hardest case to reach is a repeated START that arrives while the sequencer is waiting for a pair-mode data byte. If the abort failed, the next address byte would be written into the register chosen earlier. The bench sends a subaddress, issues a repeated START, and resends the device address followed by a new pair. It then checks that the first register still holds its old value. Burst overflow needs more data bytes than there are registers in one transfer, and a truncated byte needs a STOP partway through the bits. Both come from dedicated bit-level tasks.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ADDR,
        SQ_SUB,
        SQ_PAIR,
        SQ_BURST
    } seq_st_e;

    typedef enum logic [1:0] {
        RX_OFF,
        RX_BITS,
        RX_ACK
    } rx_st_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic hdr_match(byte_t b, logic [4:0] fixed, logic [1:0] strap);
        return (b[7:3] == fixed) && (b[2:1] == strap) && !b[0];
    endfunction

    function automatic logic is_burst_code(byte_t b);
        return &b[4:0];
    endfunction

endpackage

// File: rtl/i2cw_cond_det.sv
module i2cw_cond_det
    import i2cw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev_o.scl_rise = scl_s && !scl_q;
        ev_o.scl_fall = !scl_s && scl_q;
        ev_o.start    = scl_s && scl_q && sda_q && !sda_s;
        ev_o.stop     = scl_s && scl_q && !sda_q && sda_s;
        ev_o.sda      = sda_s;
    end

endmodule

// File: rtl/i2cw_rx_byte.sv
module i2cw_rx_byte
    import i2cw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev_i,
    input  logic    ack_want_i,
    output logic    byte_vld_o,
    output byte_t   byte_o,
    output logic    ack_done_o,
    output logic    sda_oe_o
);

    rx_st_e               st;
    logic [BIT_CNT_W-1:0] cnt;
    byte_t                shreg;
    logic                 vld_q;
    logic                 oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RX_OFF;
            cnt   <= '0;
            shreg <= '0;
            vld_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (ev_i.start) begin
                st   <= RX_BITS;
                cnt  <= '0;
                oe_q <= 1'b0;
            end else if (ev_i.stop) begin
                st   <= RX_OFF;
                oe_q <= 1'b0;
            end else begin
                unique case (st)
                    RX_BITS: begin
                        if (ev_i.scl_rise && (int'(cnt) < BYTE_W)) begin
                            shreg <= {shreg[BYTE_W-2:0], ev_i.sda};
                            cnt   <= cnt + BIT_CNT_W'(1);
                            vld_q <= (int'(cnt) == BYTE_W - 1);
                        end else if (ev_i.scl_fall && (int'(cnt) == BYTE_W)) begin
                            if (ack_want_i) begin
                                oe_q <= 1'b1;
                                st   <= RX_ACK;
                            end else begin
                                st <= RX_OFF;
                            end
                        end
                    end
                    RX_ACK: begin
                        if (ev_i.scl_fall) begin
                            oe_q <= 1'b0;
                            cnt  <= '0;
                            st   <= RX_BITS;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign byte_vld_o = vld_q;
    assign byte_o     = shreg;
    assign ack_done_o = (st == RX_ACK) && ev_i.scl_fall && !ev_i.start && !ev_i.stop;
    assign sda_oe_o   = oe_q;

endmodule

// File: rtl/i2cw_regbank.sv
module i2cw_regbank
    import i2cw_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  byte_t                data_i,
    output logic [NREG*BYTE_W-1:0] regs_o,
    output logic                 stb_o,
    output logic [IDX_W-1:0]     stb_idx_o
);

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            byte_t r_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    r_q <= '0;
                end else if (we_i && (idx_i == IDX_W'(g))) begin
                    r_q <= data_i;
                end
            end
            assign regs_o[g*BYTE_W +: BYTE_W] = r_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_o     <= 1'b0;
            stb_idx_o <= '0;
        end else begin
            stb_o <= we_i;
            if (we_i) begin
                stb_idx_o <= idx_i;
            end
        end
    end

endmodule

// File: rtl/wo_i2c_regbank.sv
module wo_i2c_regbank
    import i2cw_pkg::*;
#(
    parameter int         NREG        = 8,
    parameter logic [4:0] ADDR_FIXED  = 5'b10011,
    parameter int         SYNC_STAGES = 2,
    localparam int        IDX_W       = $clog2(NREG),
    localparam int        PTR_W       = IDX_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    input  logic [1:0]             strap_i,
    output logic [NREG*BYTE_W-1:0] regs_o,
    output logic                   wr_stb_o,
    output logic [IDX_W-1:0]       wr_idx_o
);

    bus_ev_t          ev;
    logic             byte_vld;
    byte_t            rx_byte;
    logic             ack_done;
    logic             ack_want;
    seq_st_e          st;
    byte_t            held;
    byte_t            sub_q;
    logic [PTR_W-1:0] ptr;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    i2cw_cond_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2cw_rx_byte u_rx (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .ack_want_i (ack_want),
        .byte_vld_o (byte_vld),
        .byte_o     (rx_byte),
        .ack_done_o (ack_done),
        .sda_oe_o   (sda_oe_o)
    );

    // Sequencer: address, then subaddress, then pair data or burst data.
    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            held     <= '0;
            sub_q    <= '0;
            ptr      <= '0;
            ack_want <= 1'b0;
        end else if (ev.start) begin
            st       <= SQ_ADDR;
            ack_want <= 1'b0;
        end else if (ev.stop) begin
            st       <= SQ_IDLE;
            ack_want <= 1'b0;
        end else begin
            if (byte_vld) begin
                held     <= rx_byte;
                ack_want <= (st == SQ_ADDR) ? hdr_match(rx_byte, ADDR_FIXED, strap_i)
                                            : (st != SQ_IDLE);
            end
            if (ack_done) begin
                unique case (st)
                    SQ_ADDR: st <= SQ_SUB;
                    SQ_SUB: begin
                        if (is_burst_code(held)) begin
                            st  <= SQ_BURST;
                            ptr <= '0;
                        end else begin
                            sub_q <= held;
                            st    <= SQ_PAIR;
                        end
                    end
                    SQ_PAIR: st <= SQ_SUB;
                    SQ_BURST: begin
                        if (int'(ptr) < NREG) begin
                            ptr <= ptr + PTR_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        wr_en  = 1'b0;
        wr_idx = '0;
        if (ack_done) begin
            if (st == SQ_PAIR) begin
                wr_en  = int'(sub_q) < NREG;
                wr_idx = sub_q[IDX_W-1:0];
            end else if (st == SQ_BURST) begin
                wr_en  = int'(ptr) < NREG;
                wr_idx = ptr[IDX_W-1:0];
            end
        end
    end

    i2cw_regbank #(.NREG(NREG), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .we_i      (wr_en),
        .idx_i     (wr_idx),
        .data_i    (held),
        .regs_o    (regs_o),
        .stb_o     (wr_stb_o),
        .stb_idx_o (wr_idx_o)
    );

endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
    parameter int NREG = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_oe_o,
    input logic [NREG*8-1:0] regs_o,
    input logic              wr_stb_o
);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (regs_o == '0 && !sda_oe_o && !wr_stb_o));

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !wr_stb_o);

    // R9
    regs_change_strobed_chk: assert property (@(posedge clk) disable iff (rst)
        (regs_o != $past(regs_o)) |-> wr_stb_o);

    // R3
    ack_take_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !scl_i);

    // R3
    ack_release_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe_o) |-> !scl_i);

endmodule

bind wo_i2c_regbank i2cw_checker #(.NREG(NREG)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .regs_o   (regs_o),
    .wr_stb_o (wr_stb_o)
);

// File: tb/wo_i2c_regbank_test.sv
module wo_i2c_regbank_test;

    localparam int QTR = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic [1:0]  strap = 2'b10;
    logic        sda_line;
    logic        sda_oe;
    logic [63:0] regs;
    logic        wr_stb;
    logic [2:0]  wr_idx;

    int checks = 0;
    int failures = 0;
    int stb_cycles = 0;
    int stb_rises = 0;
    logic stb_prev = 1'b0;
    logic [2:0] last_idx = '0;
    logic [7:0] exp_r [8];

    assign sda_line = ~(m_low | sda_oe);

    always #5 clk = ~clk;

    wo_i2c_regbank uut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .strap_i  (strap),
        .regs_o   (regs),
        .wr_stb_o (wr_stb),
        .wr_idx_o (wr_idx)
    );

    always @(posedge clk) begin
        stb_prev <= wr_stb;
        if (wr_stb) begin
            stb_cycles <= stb_cycles + 1;
            last_idx   <= wr_idx;
        end
        if (wr_stb && !stb_prev) stb_rises <= stb_rises + 1;
    end

    function automatic logic [63:0] exp_pack();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = exp_r[i];
        return v;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_regs(input string req, input string what);
        check(regs === exp_pack(), req, what, regs, exp_pack());
    endtask

    task automatic wq();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wq();
        scl = 1'b1;   wq();
        m_low = 1'b1; wq();
        scl = 1'b0;   wq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq();
        scl = 1'b1;   wq();
        m_low = 1'b0; wq(); wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = ~b[i]; wq();
            scl = 1'b1;    wq(); wq();
            scl = 1'b0;    wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_low = 1'b0; wq();
        scl = 1'b1;   wq();
        ack = ~sda_line; wq();
        scl = 1'b0;   wq();
    endtask

    task automatic t_reset();
        check(regs === 64'h0, "R10", "regs after reset", regs, 64'h0);
        check(sda_oe === 1'b0, "R10", "sda_oe after reset", {63'h0, sda_oe}, 64'h0);
        check(wr_stb === 1'b0, "R10", "strobe after reset", {63'h0, wr_stb}, 64'h0);
    endtask

    task automatic t_pair();
        logic a0, a1, a2, a3, a4;
        int s0;
        s0 = stb_rises;
        bus_start();
        send_byte(8'h9C, a0);
        send_byte(8'h02, a1);
        send_byte(8'hA5, a2);
        send_byte(8'h05, a3);
        send_byte(8'h3C, a4);
        bus_stop();
        exp_r[2] = 8'hA5; exp_r[5] = 8'h3C;
        check(a0, "R1", "matching address acked", {63'h0, a0}, 64'h1);
        check(a1 && a2 && a3 && a4, "R3", "sub/data acks", {60'h0, a1, a2, a3, a4}, 64'hF);
        chk_regs("R4", "pair writes");
        check(stb_rises - s0 == 2, "R9", "strobe count", 64'(stb_rises - s0), 64'd2);
        check(last_idx == 3'd5, "R9", "last write index", {61'h0, last_idx}, 64'd5);
        check(stb_cycles == stb_rises, "R9", "strobe width", 64'(stb_cycles), 64'(stb_rises));
    endtask

    task automatic t_wrong_addr();
        logic a0, a1, a2;
        bus_start();
        send_byte(8'h9A, a0);
        send_byte(8'h03, a1);
        send_byte(8'h77, a2);
        bus_stop();
        check(!a0 && !a1 && !a2, "R1", "wrong strap address not acked", {61'h0, a0, a1, a2}, 64'h0);
        chk_regs("R1", "no write after wrong address");
    endtask

    task automatic t_read_hdr();
        logic a0, a1;
        int s0;
        s0 = stb_rises;
        bus_start();
        send_byte(8'h9D, a0);
        send_byte(8'h02, a1);
        bus_stop();
        check(!a0, "R2", "read header not acked", {63'h0, a0}, 64'h0);
        check(stb_rises == s0, "R2", "no strobe after read header", 64'(stb_rises - s0), 64'd0);
        chk_regs("R2", "regs after read header");
    endtask

    task automatic t_out_of_range();
        logic a0, a1, a2;
        int s0;
        s0 = stb_rises;
        bus_start();
        send_byte(8'h9C, a0);
        send_byte(8'h0F, a1);
        send_byte(8'h77, a2);
        bus_stop();
        check(a1 && a2, "R5", "out-of-range pair acked", {62'h0, a1, a2}, 64'h3);
        check(stb_rises == s0, "R5", "no strobe", 64'(stb_rises - s0), 64'd0);
        chk_regs("R5", "regs unchanged");
    endtask

    task automatic t_burst_full();
        logic a;
        logic all_ack;
        int s0;
        s0 = stb_rises;
        all_ack = 1'b1;
        bus_start();
        send_byte(8'h9C, a);
        send_byte(8'hFF, a); all_ack &= a;
        for (int i = 0; i < 10; i++) begin
            send_byte(8'hB0 + 8'(i), a);
            all_ack &= a;
            if (i < 8) exp_r[i] = 8'hB0 + 8'(i);
        end
        bus_stop();
        chk_regs("R6", "burst fills bank in order");
        check(all_ack, "R7", "overflow bytes acked", {63'h0, all_ack}, 64'h1);
        check(stb_rises - s0 == 8, "R7", "overflow discarded", 64'(stb_rises - s0), 64'd8);
    endtask

    task automatic t_burst_short();
        logic a;
        bus_start();
        send_byte(8'h9C, a);
        send_byte(8'h1F, a);
        for (int i = 0; i < 3; i++) begin
            send_byte(8'hC0 + 8'(i), a);
            exp_r[i] = 8'hC0 + 8'(i);
        end
        bus_stop();
        chk_regs("R6", "short burst from register 0");
    endtask

    task automatic t_restart();
        logic a;
        bus_start();
        send_byte(8'h9C, a);
        send_byte(8'h04, a);
        bus_start();
        send_byte(8'h9C, a);
        send_byte(8'h06, a);
        send_byte(8'h5A, a);
        bus_stop();
        exp_r[6] = 8'h5A;
        chk_regs("R8", "repeated start aborts pair");
    endtask

    task automatic t_partial();
        logic a;
        int s0;
        s0 = stb_rises;
        bus_start();
        send_byte(8'h9C, a);
        send_byte(8'h01, a);
        send_bits(8'hFF, 4);
        bus_stop();
        check(stb_rises == s0, "R11", "truncated byte no strobe", 64'(stb_rises - s0), 64'd0);
        chk_regs("R11", "truncated byte writes nothing");
        bus_start();
        send_byte(8'h9C, a);
        send_byte(8'h01, a);
        send_byte(8'h11, a);
        bus_stop();
        exp_r[1] = 8'h11;
        chk_regs("R11", "transfer after stop");
    endtask

    task automatic t_strap();
        logic a0, a1;
        strap = 2'b01;
        wq();
        bus_start();
        send_byte(8'h9C, a0);
        bus_stop();
        bus_start();
        send_byte(8'h9A, a1);
        send_byte(8'h07, a1);
        send_byte(8'hE7, a1);
        bus_stop();
        exp_r[7] = 8'hE7;
        check(!a0, "R1", "old address refused after strap change", {63'h0, a0}, 64'h0);
        chk_regs("R1", "new strap address writes");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) exp_r[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        wq();
        t_reset();
        t_pair();
        t_wrong_addr();
        t_read_hdr();
        t_out_of_range();
        t_burst_full();
        t_burst_short();
        t_restart();
        t_partial();
        t_strap();
        check(stb_cycles == stb_rises, "R9", "strobe width overall", 64'(stb_cycles), 64'(stb_rises));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule